// File: doc/BRIEF.md
# I2C Message Sequencer

This block runs one complete I2C master message on its own, with no processor involved. It sits above a byte-level I2C core. That core raises an event flag and reports an 8-bit status code each time a bus phase completes. For each event, the sequencer chooses its next step from the status code and the message fields it latched. It then performs exactly one action: a control-register write to the core, sometimes paired with a write of a byte into the core's data register. The core is expected to clear its event flag in response to that control write.

A message request carries:
- a 10-bit target address;
- a read/write direction;
- a 10-bit addressing flag;
- a flag that skips the start and address phases;
- a byte count.

The sequencer builds the address bytes itself. It pulls write bytes from a valid/ready input stream and pushes received bytes onto a valid/ready output stream. Ahead of the last read byte it withdraws acknowledge-enable, so the core answers that byte with a NACK. Every message ends in a stop condition and a one-cycle `done` pulse carrying a result code. An abort input, or a built-in inactivity timeout, ends a message early. If the core then stays silent, the block reports the bus as locked.

The core handshake and the two streams follow these rules:
- **Core event flag.** The flag must fall within the cycle after `core_cwe`. A flag still high one cycle later is taken as a new event.
- **Write stream.** `wr_ready` is high only while an event is waiting for a byte. A beat is taken on `wr_valid && wr_ready`. While `wr_valid` is low the action stalls.
- **Read stream.** `rd_valid` stays high and `rd_data` holds until `rd_ready`. While a byte is still held, any event that would receive another byte stalls.

Top module: `i2c_msg_seq`

## Requirements
Control-register bits: acknowledge-enable is bit 2, stop is bit 4, start is bit 5, core-enable is bit 6 and interrupt-enable is bit 7. Result codes on `err_code`: 0 success, 1 no device, 2 unexpected status, 3 aborted, 4 bus locked.

- R1: In 7-bit mode, on status 0x08 or 0x10 the sequencer writes the first address byte `{addr[6:0], rd}` into the data register, together with control value 0xC4.
- R2: In 10-bit mode, the first address byte is `{5'b11110, addr[9:8], rd}`. On status 0x18 (write) or 0x40 (read), the second byte `addr[7:0]` is sent with control value 0xC4.
- R3: Before any request the block issues no core write and shows `req_ready=1`. A normal request makes its first action a control write with start, acknowledge-enable, core-enable and interrupt-enable set (0xE4), two cycles after acceptance. With skip-start, a read's first action is a plain control write of 0xC4, and a write's first action sends data byte 0.
- R4: In the write data phase (status 0x28, status 0xD0, or status 0x18 in 7-bit mode), each event sends the next stream byte with control value 0xC4 while the count is nonzero. Otherwise it writes 0x54 (stop) and pulses `done` with code 0.
- R5: In the read phase, status 0xE0 (or 0x40 in 7-bit mode) with a zero count writes stop. With a nonzero count it writes a plain control value. Each status 0x50 delivers `core_rdata` on the read stream and decrements the count. Acknowledge-enable is cleared in the control write that leaves exactly one byte outstanding. Status 0x58 delivers the final byte, writes stop, and pulses `done` with code 0.
- R6: Status 0x20, 0x30 or 0x48 writes stop and ends the message with code 1.
- R7: Any status not listed in R1 to R6 (including a NACK on the second address byte) writes stop and ends the message with code 2.
- R8: Every stop write has bit 4 set and bits 7 and 5 clear. An event while idle gets a stop write and produces no `done`.
- R9: While an event waits for write data and `wr_valid` is low, no core write occurs and `wr_ready` stays high.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_data` holds and any further receive action stalls.
- R11: `abort_i`, or `TMO_CYC` cycles without an action, moves a busy message to aborting. There, the next event writes stop and ends with code 3. If no event arrives within another `TMO_CYC` cycles, the message ends with code 4 and no core write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Message request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_addr | input | 10 | Target address |
| req_rd | input | 1 | 1 = read message |
| req_ten | input | 1 | 1 = 10-bit addressing |
| req_skip_start | input | 1 | Skip start and address phases |
| req_len | input | LEN_W | Data byte count |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Sequencer takes the write byte this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Consumer takes the received byte |
| rd_data | output | 8 | Received byte |
| abort_i | input | 1 | Abort request for the running message |
| done | output | 1 | One-cycle message completion pulse |
| err_code | output | 3 | Result code of the last message |
| busy | output | 1 | Message in progress |
| core_evt | input | 1 | Core event flag |
| core_status | input | 8 | Core status code |
| core_rdata | input | 8 | Core received data register |
| core_dwe | output | 1 | Data register write strobe |
| core_dout | output | 8 | Data register write value |
| core_cwe | output | 1 | Control register write strobe |
| core_cout | output | 8 | Control register write value |

## Verification
The bench targets these corner cases and the fault each one exposes:
- **Where the NACK falls in a read.** It runs reads of lengths 0 through 5. A design that drops acknowledge-enable one event early or late writes the wrong control value on a specific event.
- **7-bit versus 10-bit addressing.** In 7-bit mode status 0x18 and 0x40 must fall through into the data phase. In 10-bit mode they must send the second address byte. Confusing the two sends the wrong byte or skips a phase.
- **Stream stalls.** It holds `wr_valid` low, and separately `rd_ready` low, while an event waits. A design that acts anyway writes stale data to the core or overwrites an unread byte.
- **Abort and lock paths.** It checks that an abort ends with code 3 on the next event. It also checks that a silent bus ends with code 4 without touching the core.

// File: rtl/i2c_msg_seq_pkg.sv
package i2c_msg_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_KICK, S_WSTART, S_WADR1, S_WADR2, S_WACK, S_RDATA, S_ABORT
  } seq_st_e;

  typedef enum logic [2:0] {
    E_OK = 3'd0, E_NODEV = 3'd1, E_BUS = 3'd2, E_ABORT = 3'd3, E_LOCK = 3'd4
  } err_e;

  // control register bit positions decoded by the core
  localparam int CB_ACK   = 2;
  localparam int CB_STOP  = 4;
  localparam int CB_START = 5;
  localparam int CB_EN    = 6;
  localparam int CB_IEN   = 7;
  localparam logic [7:0] CTL_INIT = 8'hC4;

  // core status codes
  localparam logic [7:0] SC_START    = 8'h08;
  localparam logic [7:0] SC_RSTART   = 8'h10;
  localparam logic [7:0] SC_WA_ACK   = 8'h18;
  localparam logic [7:0] SC_WA_NAK   = 8'h20;
  localparam logic [7:0] SC_WD_ACK   = 8'h28;
  localparam logic [7:0] SC_WD_NAK   = 8'h30;
  localparam logic [7:0] SC_RA_ACK   = 8'h40;
  localparam logic [7:0] SC_RA_NAK   = 8'h48;
  localparam logic [7:0] SC_RD_ACK   = 8'h50;
  localparam logic [7:0] SC_RD_NAK   = 8'h58;
  localparam logic [7:0] SC_WA2_ACK  = 8'hD0;
  localparam logic [7:0] SC_RA2_ACK  = 8'hE0;

endpackage

// File: rtl/i2c_seq_adrfmt.sv
module i2c_seq_adrfmt (
  input  logic [9:0] addr,
  input  logic       rd,
  input  logic       ten,
  output logic [7:0] first,
  output logic [7:0] second
);
  // 10-bit header: fixed 11110 prefix, high address bits, direction
  always_comb begin
    if (ten) first = {5'b11110, addr[9:8], rd};
    else     first = {addr[6:0], rd};
    second = addr[7:0];
  end
endmodule

// File: rtl/i2c_seq_wdog.sv
module i2c_seq_wdog #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr || !run)      cnt <= '0;
    else if (!expired)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2c_msg_seq_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int TMO_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [9:0]       req_addr,
  input  logic             req_rd,
  input  logic             req_ten,
  input  logic             req_skip_start,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  input  logic             abort_i,
  output logic             done,
  output logic [2:0]       err_code,
  output logic             busy,
  input  logic             core_evt,
  input  logic [7:0]       core_status,
  input  logic [7:0]       core_rdata,
  output logic             core_dwe,
  output logic [7:0]       core_dout,
  output logic             core_cwe,
  output logic [7:0]       core_cout
);

  seq_st_e          st, nst;
  logic [9:0]       addr_q;
  logic             rd_q, ten_q, skip_q;
  logic [LEN_W-1:0] left_q;
  logic [7:0]       cntl_q, cntl_n, cout_n, dout_n, adr1, adr2;
  logic             go, dwe_n, set_stop, set_start, fin, dec, clr_ack, rtake;
  logic             tmo, accept, is_w, is_a2, is_rfirst, live;
  err_e             ec_n;

  i2c_seq_adrfmt u_fmt (
    .addr(addr_q), .rd(rd_q), .ten(ten_q), .first(adr1), .second(adr2)
  );

  i2c_seq_wdog #(.LIMIT(TMO_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run(st != S_IDLE),
    .clr(go || (nst != st) || accept), .expired(tmo)
  );

  assign req_ready = (st == S_IDLE) && !core_evt;
  assign accept    = req_valid && req_ready;
  assign busy      = (st != S_IDLE);
  assign live      = (st != S_IDLE) && (st != S_ABORT);

  always_comb begin
    go = 1'b0; nst = st; dwe_n = 1'b0; dout_n = 8'h00; set_stop = 1'b0;
    set_start = 1'b0; fin = 1'b0; ec_n = E_OK; dec = 1'b0; clr_ack = 1'b0;
    rtake = 1'b0; wr_ready = 1'b0;
    is_a2 = ten_q && (core_status == SC_WA_ACK || core_status == SC_RA_ACK);
    is_w  = (core_status == SC_WD_ACK) || (core_status == SC_WA2_ACK) ||
            (core_status == SC_WA_ACK && !ten_q);
    is_rfirst = (core_status == SC_RA2_ACK) || (core_status == SC_RA_ACK && !ten_q);
    case (st)
      S_IDLE: if (core_evt) set_stop = 1'b1;  // leftover event: release bus
      S_KICK: begin
        if (!skip_q) begin
          go = 1'b1; set_start = 1'b1; nst = S_WSTART;
        end else if (rd_q) begin
          go = 1'b1; nst = S_RDATA;
        end else if (left_q == '0) begin
          set_stop = 1'b1; fin = 1'b1;
        end else begin
          wr_ready = 1'b1;
          if (wr_valid) begin
            go = 1'b1; dwe_n = 1'b1; dout_n = wr_data; dec = 1'b1; nst = S_WACK;
          end
        end
      end
      S_ABORT: begin
        if (core_evt) begin
          set_stop = 1'b1; fin = 1'b1; ec_n = E_ABORT;
        end else if (tmo) begin
          fin = 1'b1; ec_n = E_LOCK; nst = S_IDLE;
        end
      end
      default: if (core_evt) begin
        if (core_status == SC_START || core_status == SC_RSTART) begin
          go = 1'b1; dwe_n = 1'b1; dout_n = adr1; nst = S_WADR1;
        end else if (is_a2) begin
          go = 1'b1; dwe_n = 1'b1; dout_n = adr2; nst = S_WADR2;
        end else if (is_w) begin
          if (left_q == '0) begin
            set_stop = 1'b1; fin = 1'b1;
          end else begin
            wr_ready = 1'b1;
            if (wr_valid) begin
              go = 1'b1; dwe_n = 1'b1; dout_n = wr_data; dec = 1'b1; nst = S_WACK;
            end
          end
        end else if (is_rfirst && left_q == '0) begin
          set_stop = 1'b1; fin = 1'b1;
        end else if (is_rfirst) begin
          go = 1'b1; nst = S_RDATA; clr_ack = (left_q == LEN_W'(1));
        end else if (core_status == SC_RD_ACK) begin
          if (!rd_valid) begin
            go = 1'b1; rtake = 1'b1; dec = 1'b1; nst = S_RDATA;
            clr_ack = (left_q == LEN_W'(2));
          end
        end else if (core_status == SC_RD_NAK) begin
          if (!rd_valid) begin
            rtake = 1'b1; set_stop = 1'b1; fin = 1'b1;
          end
        end else if (core_status == SC_WA_NAK || core_status == SC_WD_NAK ||
                     core_status == SC_RA_NAK) begin
          set_stop = 1'b1; fin = 1'b1; ec_n = E_NODEV;
        end else begin
          set_stop = 1'b1; fin = 1'b1; ec_n = E_BUS;
        end
      end
    endcase
    if (set_stop) begin
      go = 1'b1; nst = S_IDLE;
    end
    if (live && !go && (abort_i || tmo)) nst = S_ABORT;
    cntl_n = cntl_q;
    if (clr_ack)  cntl_n[CB_ACK] = 1'b0;
    if (set_stop) cntl_n[CB_IEN] = 1'b0;
    cout_n = cntl_n;
    cout_n[CB_STOP]  = set_stop;
    cout_n[CB_START] = set_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; addr_q <= '0; rd_q <= 1'b0; ten_q <= 1'b0; skip_q <= 1'b0;
      left_q <= '0; cntl_q <= '0; core_cwe <= 1'b0; core_dwe <= 1'b0;
      core_cout <= '0; core_dout <= '0; done <= 1'b0; err_code <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      st       <= nst;
      core_cwe <= go;
      core_dwe <= go && dwe_n;
      if (go) begin
        core_cout <= cout_n; core_dout <= dout_n; cntl_q <= cntl_n;
      end
      done <= fin;
      if (fin) err_code <= ec_n;
      if (dec) left_q <= left_q - 1'b1;
      if (rtake) begin
        rd_valid <= 1'b1; rd_data <= core_rdata;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
      if (accept) begin
        addr_q <= req_addr; rd_q <= req_rd; ten_q <= req_ten;
        skip_q <= req_skip_start; left_q <= req_len; cntl_q <= CTL_INIT;
        st <= S_KICK;
      end
    end
  end

  // R3: a normal request opens with a start write carrying the run bits
  p_kick_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_skip_start) |-> ##2
      (core_cwe && core_cout[CB_START] && core_cout[CB_ACK] &&
       core_cout[CB_EN] && core_cout[CB_IEN] && !core_dwe));

  // R8: stop writes drop interrupt-enable and never combine with start
  p_stop_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_cwe && core_cout[CB_STOP]) |-> (!core_cout[CB_IEN] && !core_cout[CB_START]));

  // R6: every completion other than bus-locked coincides with a stop write
  p_done_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code != 3'(E_LOCK)) |-> (core_cwe && core_cout[CB_STOP]));

  // R9: no data write to the core while the write stream is empty
  p_wr_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> !core_dwe);

  // R10: a held received byte stays put
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R11: a locked bus is reported without touching the core
  p_lock_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'(E_LOCK)) |-> !core_cwe);

endmodule

// File: tb/i2c_msg_seq_tb.sv
`timescale 1ns/1ps
module i2c_msg_seq_tb;
  localparam int LEN_W = 8;
  localparam int TMO   = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_rd = 0, req_ten = 0, req_skip = 0;
  logic [9:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic wr_valid, wr_ready; logic [7:0] wr_data;
  logic rd_valid, rd_ready = 1'b1; logic [7:0] rd_data;
  logic abort_i = 0, done, busy, req_ready; logic [2:0] err_code;
  logic core_evt = 0; logic [7:0] core_status = '0, core_rdata = '0;
  logic core_dwe, core_cwe; logic [7:0] core_dout, core_cout;

  i2c_msg_seq #(.LEN_W(LEN_W), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rd(req_rd), .req_ten(req_ten),
    .req_skip_start(req_skip), .req_len(req_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .abort_i(abort_i), .done(done),
    .err_code(err_code), .busy(busy), .core_evt(core_evt),
    .core_status(core_status), .core_rdata(core_rdata), .core_dwe(core_dwe),
    .core_dout(core_dout), .core_cwe(core_cwe), .core_cout(core_cout)
  );

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  int lcnt = 0, last_ent = 0, dcnt = 0, derr = 0, rcnt = 0, wpos = 0, wend = 0;
  logic wgate = 1'b1;
  logic [7:0] wbuf [0:1023];
  logic [7:0] rbuf [0:1023];
  logic [7:0] ebuf [0:15];

  assign wr_valid = wgate && (wpos < wend);
  assign wr_data  = wbuf[10'(wpos)];

  always @(posedge clk) begin
    if (core_cwe) begin
      last_ent <= {15'd0, core_dwe, core_dwe ? core_dout : 8'h00, core_cout};
      lcnt <= lcnt + 1;
    end
    if (done) begin dcnt <= dcnt + 1; derr <= int'(err_code); end
    if (rd_valid && rd_ready) begin rbuf[10'(rcnt)] <= rd_data; rcnt <= rcnt + 1; end
    if (wr_valid && wr_ready) wpos <= wpos + 1;
  end

  // core model: the event flag falls after the control write
  always @(negedge clk) if (core_cwe) core_evt <= 1'b0;

  function automatic int ent(bit dwe, logic [7:0] d, logic [7:0] c);
    return {15'd0, dwe, d, c};
  endfunction

  function automatic logic [7:0] f_a1(logic [9:0] a, bit rd, bit ten);
    return ten ? {5'b11110, a[9:8], rd} : {a[6:0], rd};
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_log(int n0);
    for (int i = 0; i < 300 && lcnt == n0; i++) @(negedge clk);
    if (lcnt == n0) chk("core action missing", 0, 1);
  endtask

  task automatic raise(logic [7:0] s, logic [7:0] rdat);
    @(negedge clk);
    core_status = s; core_rdata = rdat; core_evt = 1'b1;
  endtask

  task automatic step(logic [7:0] s, logic [7:0] rdat);
    int n0 = lcnt;
    raise(s, rdat);
    wait_log(n0);
  endtask

  task automatic send_req(bit rd, bit ten, bit skip, logic [9:0] a, int len);
    @(negedge clk);
    req_rd = rd; req_ten = ten; req_skip = skip; req_addr = a;
    req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(int len);
    for (int i = 0; i < len; i++) begin
      wbuf[10'(wpos + i)] = 8'($urandom);
      ebuf[i] = 8'($urandom);
    end
  endtask

  task automatic run_msg(bit rd, bit ten, logic [9:0] a, int len);
    int d0, r0, wb, n0; logic [7:0] c;
    fill(len);
    wb = wpos; d0 = dcnt; r0 = rcnt; n0 = lcnt;
    wend = rd ? wpos : wpos + len;
    send_req(rd, ten, 1'b0, a, len);
    wait_log(n0);
    chk("R3 start write", last_ent, ent(0, 8'h00, 8'hE4));
    step(8'h08, 8'h00);
    chk(ten ? "R2 first address byte" : "R1 address byte", last_ent,
        ent(1, f_a1(a, rd, ten), 8'hC4));
    if (ten) begin
      step(rd ? 8'h40 : 8'h18, 8'h00);
      chk("R2 second address byte", last_ent, ent(1, a[7:0], 8'hC4));
    end
    if (!rd) begin
      for (int j = 0; j <= len; j++) begin
        step((j != 0) ? 8'h28 : (ten ? 8'hD0 : 8'h18), 8'h00);
        if (j < len) chk("R4 data byte", last_ent, ent(1, wbuf[10'(wb + j)], 8'hC4));
        else         chk("R4 stop after last byte", last_ent, ent(0, 8'h00, 8'h54));
      end
    end else begin
      c = 8'hC4;
      step(ten ? 8'hE0 : 8'h40, 8'h00);
      if (len == 0) chk("R5 empty read stop", last_ent, ent(0, 8'h00, 8'h54));
      else begin
        if (len == 1) c = 8'hC0;
        chk("R5 read phase entry", last_ent, ent(0, 8'h00, c));
        for (int k = len; k >= 2; k--) begin
          step(8'h50, ebuf[len - k]);
          if (k - 1 == 1) c = 8'hC0;
          chk("R5 ack-enable per byte", last_ent, ent(0, 8'h00, c));
        end
        step(8'h58, ebuf[len - 1]);
        chk("R5 final byte stop", last_ent, ent(0, 8'h00, 8'h50));
      end
    end
    repeat (3) @(negedge clk);
    chk("R4 R5 done pulse", dcnt - d0, 1);
    chk("R4 R5 success code", derr, 0);
    if (rd) begin
      chk("R5 bytes delivered", rcnt - r0, len);
      for (int i = 0; i < len; i++)
        chk("R5 read byte value", int'(rbuf[10'(r0 + i)]), int'(ebuf[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n0, d0, r0;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset req_ready", int'(req_ready), 1);
    chk("R3 reset busy", int'(busy), 0);
    chk("R3 reset no core write", lcnt, 0);
    chk("R3 reset rd_valid", int'(rd_valid), 0);

    // directed messages
    run_msg(0, 0, 10'h05A, 3);
    run_msg(0, 1, 10'h2C3, 2);
    run_msg(1, 0, 10'h031, 1);
    run_msg(1, 0, 10'h031, 2);
    run_msg(1, 1, 10'h1E7, 4);
    run_msg(1, 0, 10'h07F, 0);
    run_msg(0, 0, 10'h012, 0);

    // R6: NACK on address
    d0 = dcnt; n0 = lcnt;
    send_req(0, 0, 0, 10'h033, 1); wait_log(n0);
    step(8'h08, 0); step(8'h20, 0);
    chk("R6 stop on address nack", last_ent, ent(0, 8'h00, 8'h54));
    repeat (2) @(negedge clk);
    chk("R6 no-device code", derr, 1);
    chk("R6 done", dcnt - d0, 1);
    n0 = lcnt;
    send_req(1, 0, 0, 10'h044, 2); wait_log(n0);
    step(8'h08, 0); step(8'h48, 0);
    repeat (2) @(negedge clk);
    chk("R6 read nack code", derr, 1);

    // R7: unexpected status
    n0 = lcnt;
    send_req(0, 1, 0, 10'h300, 1); wait_log(n0);
    step(8'h38, 0);
    chk("R7 stop on unexpected", last_ent, ent(0, 8'h00, 8'h54));
    repeat (2) @(negedge clk);
    chk("R7 bus error code", derr, 2);

    // R8: stray event while idle
    d0 = dcnt;
    step(8'hF8, 0);
    chk("R8 idle event stop bit", (last_ent >> 4) & 1, 1);
    repeat (3) @(negedge clk);
    chk("R8 idle event no done", dcnt - d0, 0);

    // R9: write stream stall
    fill(2); wend = wpos + 2; wgate = 1'b0; n0 = lcnt; r0 = wpos;
    send_req(0, 0, 0, 10'h011, 2); wait_log(n0);
    step(8'h08, 0);
    n0 = lcnt;
    raise(8'h18, 0);
    repeat (6) @(negedge clk);
    chk("R9 no action while stalled", lcnt - n0, 0);
    chk("R9 ready held", int'(wr_ready), 1);
    wgate = 1'b1;
    wait_log(n0);
    chk("R9 byte after stall", last_ent, ent(1, wbuf[10'(r0)], 8'hC4));
    step(8'h28, 0);
    step(8'h28, 0);
    chk("R9 stop", last_ent, ent(0, 8'h00, 8'h54));

    // R10: read stream back-pressure
    rd_ready = 1'b0; n0 = lcnt; r0 = rcnt;
    send_req(1, 0, 0, 10'h022, 3); wait_log(n0);
    step(8'h08, 0); step(8'h40, 0);
    step(8'h50, 8'hA1);
    chk("R10 first byte keeps ack", last_ent, ent(0, 8'h00, 8'hC4));
    n0 = lcnt;
    raise(8'h50, 8'hB2);
    repeat (6) @(negedge clk);
    chk("R10 receive stalled", lcnt - n0, 0);
    chk("R10 byte held", int'(rd_data), 8'hA1);
    rd_ready = 1'b1;
    wait_log(n0);
    chk("R10 ack cleared before last", last_ent, ent(0, 8'h00, 8'hC0));
    step(8'h58, 8'hC3);
    repeat (3) @(negedge clk);
    chk("R10 bytes delivered", rcnt - r0, 3);
    chk("R10 second byte", int'(rbuf[10'(r0 + 1)]), 8'hB2);

    // R3: skip-start write and read
    fill(1); wend = wpos + 1; r0 = wpos; n0 = lcnt;
    send_req(0, 0, 1, 10'h000, 1); wait_log(n0);
    chk("R3 skip-start write data first", last_ent, ent(1, wbuf[10'(r0)], 8'hC4));
    step(8'h28, 0);
    chk("R3 skip-start write stop", last_ent, ent(0, 8'h00, 8'h54));
    n0 = lcnt; r0 = rcnt;
    send_req(1, 0, 1, 10'h000, 2); wait_log(n0);
    chk("R3 skip-start read continue", last_ent, ent(0, 8'h00, 8'hC4));
    step(8'h50, 8'h5E);
    chk("R3 skip-start read ack clear", last_ent, ent(0, 8'h00, 8'hC0));
    step(8'h58, 8'h6F);
    repeat (3) @(negedge clk);
    chk("R3 skip-start read bytes", rcnt - r0, 2);

    // R11: abort then event
    fill(2); wend = wpos + 2; n0 = lcnt; d0 = dcnt;
    send_req(0, 0, 0, 10'h055, 2); wait_log(n0);
    step(8'h08, 0);
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    step(8'h18, 0);
    chk("R11 abort stop write", last_ent, ent(0, 8'h00, 8'h54));
    repeat (2) @(negedge clk);
    chk("R11 aborted code", derr, 3);
    chk("R11 abort done", dcnt - d0, 1);

    // R11: silent bus -> timeout -> bus locked
    n0 = lcnt; d0 = dcnt;
    send_req(0, 0, 0, 10'h066, 1); wait_log(n0);
    n0 = lcnt;
    for (int i = 0; i < 300 && dcnt == d0; i++) @(negedge clk);
    chk("R11 lock done", dcnt - d0, 1);
    chk("R11 locked code", derr, 4);
    chk("R11 lock no core write", lcnt - n0, 0);
    chk("R11 idle after lock", int'(busy), 0);

    // random messages
    for (int m = 0; m < 24; m++)
      run_msg(1'($urandom), 1'($urandom), 10'($urandom), int'($urandom % 6));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule